// File: doc/BRIEF.md
# Disk Controller Interrupt Source Tracker

This block decides when a floppy-style disk controller raises its interrupt line, and it keeps track of why. Two families of causes are handled differently. Some interrupts belong to the normal command flow: the sequencer entering the result phase of a data command, and per-byte service requests while a command executes without DMA. These are cleared as soon as the host touches the data register. The other causes come from outside the command flow: a drive's ready line toggling, or a seek or recalibrate finishing. These stay pending until the host issues a sense-interrupt command.

Each drive has its own pending seek-end slot and its own pending ready-change slot. Each sense-interrupt strobe retires exactly one event, taking the lowest-numbered drive first. Within a drive, a seek end is reported before a ready change. The strobe latches a status-0 byte and the drive's last reported cylinder. The interrupt line stays high while any event is still queued.

The block also supplies two things to the main status register: the non-DMA execution flag and the per-drive seek-busy bits.

Top module: `disk_irq_tracker`

## Requirements
- R1: One cycle after a `result_enter_i` pulse, `irq_o` is 1 and `msr_ndma_o` is 0.
- R2: An `exec_begin_i` pulse sets `msr_ndma_o` one cycle later when `non_dma_i` is 1. When `non_dma_i` is 0 the pulse leaves the flag at 0.
- R3: `byte_req_i` raises `irq_o` one cycle later only while `msr_ndma_o` is 1. When the flag is 0, the strobe has no effect on `irq_o`.
- R4: A data-register read or write (`data_rd_i`/`data_wr_i`) clears an interrupt raised by R1 or R3 one cycle later. If a raising event arrives in the same cycle, the raise wins.
- R5: A `seek_done_i` pulse queues a seek-end event for drive `seek_drv_i` and records `seek_cyl_i` as that drive's cylinder. `irq_o` is 1 one cycle later. When this event is sensed, the block reports status-0 = 0x20 | drive, with bit 5 as seek end and bits 1:0 as the drive.
- R6: A `seek_done_i` pulse with `seek_fail_i` = 1 is reported as status-0 = 0x70 | drive. This encoding has bits 7:6 = 01 (abnormal end), bit 5 set (seek end) and bit 4 set (equipment check).
- R7: A change in either direction on `ready_i[d]` queues a ready-change event. It is reported as status-0 = 0xC0 | d, with bits 7:6 = 11. The value seen on the first clock after reset is taken as the baseline and raises nothing.
- R8: Data-register accesses do not retire queued seek-end or ready-change events. `irq_o` stays 1 while any event is queued.
- R9: Each `sense_i` strobe retires one queued event and latches its status-0 and the drive's cylinder, with `sense_nbytes_o` = 2. The lowest drive goes first, and within a drive the seek end goes before the ready change.
- R10: A `sense_i` strobe with nothing queued returns `sense_st0_o` = 0x80 and `sense_nbytes_o` = 1.
- R11: `msr_busy_o[d]` is set one cycle after `seek_start_i` for drive d. It is cleared by the `sense_i` strobe that reports drive d.
- R12: After reset, `irq_o`, `msr_ndma_o`, `msr_busy_o`, `sense_st0_o`, `sense_pcn_o` and `sense_nbytes_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_enter_i | input | 1 | Sequencer enters result phase of a data command |
| exec_begin_i | input | 1 | Execution phase starts |
| non_dma_i | input | 1 | Controller is in non-DMA mode |
| byte_req_i | input | 1 | Execution phase needs a byte serviced |
| data_rd_i | input | 1 | Host read of the data register |
| data_wr_i | input | 1 | Host write of the data register |
| seek_start_i | input | 1 | Seek or recalibrate started on `seek_drv_i` |
| seek_done_i | input | 1 | Seek or recalibrate finished on `seek_drv_i` |
| seek_fail_i | input | 1 | Finished operation ended abnormally (track 0 not found) |
| seek_drv_i | input | DRV_W | Drive number for seek start/done |
| seek_cyl_i | input | CYL_W | Cylinder reached at seek done |
| ready_i | input | N | Per-drive ready lines |
| sense_i | input | 1 | Sense-interrupt command strobe |
| irq_o | output | 1 | Interrupt line |
| msr_ndma_o | output | 1 | Non-DMA execution flag for the main status register |
| msr_busy_o | output | N | Per-drive seek-busy bits |
| sense_st0_o | output | 8 | Status-0 returned by the last sense strobe |
| sense_pcn_o | output | CYL_W | Cylinder returned by the last sense strobe |
| sense_nbytes_o | output | 2 | Result length of the last sense: 1 or 2 |

## Verification
The assertions assume that every strobe input is a single-cycle pulse, that `seek_drv_i` names an existing drive whenever start or done is asserted, and that `seek_fail_i` is meaningful only together with `seek_done_i`. The bench drives each stimulus for exactly one cycle between falling edges. It only raises `byte_req_i` or the data strobes where a command would produce them, and it changes `ready_i` only after the first post-reset clock. Within those limits, the bench deliberately stacks coincident events: a raise together with a clear, several drives pending at once, and seek and ready events on the same drive.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  typedef enum logic [1:0] {
    IC_NORMAL   = 2'b00,
    IC_ABNORMAL = 2'b01,
    IC_INVALID  = 2'b10,
    IC_READY    = 2'b11
  } ic_e;

  typedef struct packed {
    ic_e        ic;
    logic       seek_end;
    logic       equip_chk;
    logic       not_ready;
    logic       head;
    logic [1:0] unit;
  } st0_t;

  localparam logic [7:0] ST0_INVALID = 8'h80;
endpackage

// File: rtl/dirq_ready_watch.sv
module dirq_ready_watch #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ready_i,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] ready_q;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      ready_q  <= ready_i;
      primed_q <= 1'b1;
    end
  end

  // first sample after reset is only a baseline
  assign chg_o = {N{primed_q}} & (ready_i ^ ready_q);
endmodule

// File: rtl/dirq_data_src.sv
module dirq_data_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic result_enter_i,
  input  logic exec_begin_i,
  input  logic non_dma_i,
  input  logic byte_req_i,
  input  logic access_i,
  output logic irq_o,
  output logic ndma_o
);
  logic irq_q, ndma_q;
  logic byte_ok;

  assign byte_ok = byte_req_i & ndma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      ndma_q <= 1'b0;
    end else begin
      if (result_enter_i)                 ndma_q <= 1'b0;
      else if (exec_begin_i && non_dma_i) ndma_q <= 1'b1;

      if (result_enter_i || byte_ok) irq_q <= 1'b1;
      else if (access_i)             irq_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign ndma_o = ndma_q;
endmodule

// File: rtl/dirq_event_queue.sv
module dirq_event_queue import dirq_pkg::*; #(
  parameter int N     = 4,
  parameter int CYL_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 seek_done_i,
  input  logic                 seek_fail_i,
  input  logic [$clog2(N)-1:0] seek_drv_i,
  input  logic [CYL_W-1:0]     seek_cyl_i,
  input  logic [N-1:0]         ready_chg_i,
  input  logic                 pop_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] sel_drv_o,
  output st0_t                 sel_st0_o,
  output logic [CYL_W-1:0]     sel_pcn_o
);
  localparam int DRV_W = $clog2(N);

  logic [N-1:0]     pend_seek, pend_rdy, fail_v;
  logic [CYL_W-1:0] pcn_arr [N];
  logic             sel_is_seek;
  logic [DRV_W-1:0] sel_drv;

  // lowest drive wins; seek end before ready change
  always_comb begin
    any_o       = 1'b0;
    sel_drv     = '0;
    sel_is_seek = 1'b0;
    for (int d = N - 1; d >= 0; d--) begin
      if (pend_seek[d] || pend_rdy[d]) begin
        any_o       = 1'b1;
        sel_drv     = DRV_W'(d);
        sel_is_seek = pend_seek[d];
      end
    end
  end

  for (genvar d = 0; d < N; d++) begin : g_drv
    logic             seek_q, rdy_q, fail_q;
    logic [CYL_W-1:0] cyl_q;
    logic             hit, take;

    assign hit  = seek_done_i && (seek_drv_i == DRV_W'(d));
    assign take = pop_i && any_o && (sel_drv == DRV_W'(d));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seek_q <= 1'b0;
        rdy_q  <= 1'b0;
        fail_q <= 1'b0;
        cyl_q  <= '0;
      end else begin
        if (hit) begin
          seek_q <= 1'b1;
          fail_q <= seek_fail_i;
          cyl_q  <= seek_cyl_i;
        end else if (take && sel_is_seek) begin
          seek_q <= 1'b0;
        end
        if (ready_chg_i[d])               rdy_q <= 1'b1;
        else if (take && !sel_is_seek)    rdy_q <= 1'b0;
      end
    end

    assign pend_seek[d] = seek_q;
    assign pend_rdy[d]  = rdy_q;
    assign fail_v[d]    = fail_q;
    assign pcn_arr[d]   = cyl_q;
  end

  always_comb begin
    sel_st0_o           = '0;
    sel_st0_o.unit      = 2'(sel_drv);
    if (sel_is_seek) begin
      sel_st0_o.ic        = fail_v[sel_drv] ? IC_ABNORMAL : IC_NORMAL;
      sel_st0_o.seek_end  = 1'b1;
      sel_st0_o.equip_chk = fail_v[sel_drv];
    end else begin
      sel_st0_o.ic        = IC_READY;
    end
  end

  assign sel_drv_o = sel_drv;
  assign sel_pcn_o = pcn_arr[sel_drv];
endmodule

// File: rtl/disk_irq_tracker.sv
module disk_irq_tracker import dirq_pkg::*; #(
  parameter int N     = 4,
  parameter int CYL_W = 8,
  parameter int DRV_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             result_enter_i,
  input  logic             exec_begin_i,
  input  logic             non_dma_i,
  input  logic             byte_req_i,
  input  logic             data_rd_i,
  input  logic             data_wr_i,
  input  logic             seek_start_i,
  input  logic             seek_done_i,
  input  logic             seek_fail_i,
  input  logic [DRV_W-1:0] seek_drv_i,
  input  logic [CYL_W-1:0] seek_cyl_i,
  input  logic [N-1:0]     ready_i,
  input  logic             sense_i,
  output logic             irq_o,
  output logic             msr_ndma_o,
  output logic [N-1:0]     msr_busy_o,
  output logic [7:0]       sense_st0_o,
  output logic [CYL_W-1:0] sense_pcn_o,
  output logic [1:0]       sense_nbytes_o
);
  logic [N-1:0]     ready_chg;
  logic             data_irq, q_any;
  logic [DRV_W-1:0] sel_drv;
  st0_t             sel_st0;
  logic [CYL_W-1:0] sel_pcn;
  logic [N-1:0]     busy_q;
  logic [7:0]       st0_q;
  logic [CYL_W-1:0] pcn_q;
  logic [1:0]       nb_q;

  dirq_ready_watch #(.N(N)) u_ready (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i), .chg_o(ready_chg)
  );

  dirq_data_src u_data (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .result_enter_i(result_enter_i), .exec_begin_i(exec_begin_i),
    .non_dma_i(non_dma_i), .byte_req_i(byte_req_i),
    .access_i(data_rd_i | data_wr_i),
    .irq_o(data_irq), .ndma_o(msr_ndma_o)
  );

  dirq_event_queue #(.N(N), .CYL_W(CYL_W)) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .seek_done_i(seek_done_i), .seek_fail_i(seek_fail_i),
    .seek_drv_i(seek_drv_i), .seek_cyl_i(seek_cyl_i),
    .ready_chg_i(ready_chg), .pop_i(sense_i),
    .any_o(q_any), .sel_drv_o(sel_drv), .sel_st0_o(sel_st0), .sel_pcn_o(sel_pcn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else begin
      for (int d = 0; d < N; d++) begin
        if (seek_start_i && seek_drv_i == DRV_W'(d))        busy_q[d] <= 1'b1;
        else if (sense_i && q_any && sel_drv == DRV_W'(d))  busy_q[d] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st0_q <= '0;
      pcn_q <= '0;
      nb_q  <= '0;
    end else if (sense_i) begin
      if (q_any) begin
        st0_q <= sel_st0;
        pcn_q <= sel_pcn;
        nb_q  <= 2'd2;
      end else begin
        st0_q <= ST0_INVALID;
        pcn_q <= '0;
        nb_q  <= 2'd1;
      end
    end
  end

  assign irq_o          = data_irq | q_any;
  assign msr_busy_o     = busy_q;
  assign sense_st0_o    = st0_q;
  assign sense_pcn_o    = pcn_q;
  assign sense_nbytes_o = nb_q;
endmodule

// File: rtl/disk_irq_tracker_chk.sv
module disk_irq_tracker_chk #(
  parameter int N     = 4,
  parameter int CYL_W = 8,
  parameter int DRV_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             result_enter_i,
  input logic             byte_req_i,
  input logic             data_rd_i,
  input logic             data_wr_i,
  input logic             seek_start_i,
  input logic             seek_done_i,
  input logic [DRV_W-1:0] seek_drv_i,
  input logic             sense_i,
  input logic             irq_o,
  input logic             msr_ndma_o,
  input logic [N-1:0]     msr_busy_o,
  input logic [7:0]       sense_st0_o,
  input logic [1:0]       sense_nbytes_o,
  input logic             q_any,
  input logic             data_irq
);
  a_r1_result_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_enter_i |=> irq_o && !msr_ndma_o);

  a_r3_byte_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_i && !msr_ndma_o && !result_enter_i && !data_irq |=> !data_irq);

  a_r4_access_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i || data_wr_i) && !result_enter_i && !byte_req_i |=> !data_irq);

  a_r5_seek_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seek_done_i |=> irq_o && q_any);

  a_r8_queue_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_any && !sense_i |=> q_any && irq_o);

  a_r9_two_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_i && q_any |=> sense_nbytes_o == 2'd2);

  a_r10_empty_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_i && !q_any |=> sense_st0_o == 8'h80 && sense_nbytes_o == 2'd1);

  a_r11_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seek_start_i |=> msr_busy_o[$past(seek_drv_i)]);
endmodule

bind disk_irq_tracker disk_irq_tracker_chk #(.N(N), .CYL_W(CYL_W), .DRV_W(DRV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .result_enter_i(result_enter_i),
  .byte_req_i(byte_req_i), .data_rd_i(data_rd_i), .data_wr_i(data_wr_i),
  .seek_start_i(seek_start_i), .seek_done_i(seek_done_i), .seek_drv_i(seek_drv_i),
  .sense_i(sense_i), .irq_o(irq_o), .msr_ndma_o(msr_ndma_o), .msr_busy_o(msr_busy_o),
  .sense_st0_o(sense_st0_o), .sense_nbytes_o(sense_nbytes_o),
  .q_any(q_any), .data_irq(data_irq)
);

// File: tb/tb_disk_irq_tracker.sv
`timescale 1ns/1ps
module tb_disk_irq_tracker;
  localparam int N = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic result_enter_i = 0, exec_begin_i = 0, non_dma_i = 0, byte_req_i = 0;
  logic data_rd_i = 0, data_wr_i = 0, seek_start_i = 0, seek_done_i = 0, seek_fail_i = 0;
  logic [1:0]    seek_drv_i = '0;
  logic [CW-1:0] seek_cyl_i = '0;
  logic [N-1:0]  ready_i = 4'b0101;
  logic          sense_i = 0;
  logic          irq_o, msr_ndma_o;
  logic [N-1:0]  msr_busy_o;
  logic [7:0]    sense_st0_o;
  logic [CW-1:0] sense_pcn_o;
  logic [1:0]    sense_nbytes_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disk_irq_tracker #(.N(N), .CYL_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .result_enter_i(result_enter_i),
    .exec_begin_i(exec_begin_i), .non_dma_i(non_dma_i), .byte_req_i(byte_req_i),
    .data_rd_i(data_rd_i), .data_wr_i(data_wr_i), .seek_start_i(seek_start_i),
    .seek_done_i(seek_done_i), .seek_fail_i(seek_fail_i), .seek_drv_i(seek_drv_i),
    .seek_cyl_i(seek_cyl_i), .ready_i(ready_i), .sense_i(sense_i),
    .irq_o(irq_o), .msr_ndma_o(msr_ndma_o), .msr_busy_o(msr_busy_o),
    .sense_st0_o(sense_st0_o), .sense_pcn_o(sense_pcn_o), .sense_nbytes_o(sense_nbytes_o)
  );

  // behavioural reference
  int m_dirq, m_ndma, m_primed, m_st0, m_pcn_out, m_nb;
  int m_seek[N], m_fail[N], m_rdy[N], m_cyl[N], m_busy[N], m_prev[N];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dirq = 0; m_ndma = 0; m_primed = 0; m_st0 = 0; m_pcn_out = 0; m_nb = 0;
      for (int d = 0; d < N; d++) begin
        m_seek[d] = 0; m_fail[d] = 0; m_rdy[d] = 0; m_cyl[d] = 0; m_busy[d] = 0; m_prev[d] = 0;
      end
    end else begin
      int found;
      int old_ndma;
      found = -1;
      if (sense_i) begin
        for (int d = 0; d < N; d++) if (found < 0 && (m_seek[d] != 0 || m_rdy[d] != 0)) found = d;
        if (found < 0) begin
          m_st0 = 'h80; m_pcn_out = 0; m_nb = 1;
        end else begin
          m_nb = 2; m_pcn_out = m_cyl[found]; m_busy[found] = 0;
          if (m_seek[found] != 0) begin
            m_st0 = (m_fail[found] != 0 ? 'h70 : 'h20) | found;
            m_seek[found] = 0;
          end else begin
            m_st0 = 'hC0 | found;
            m_rdy[found] = 0;
          end
        end
      end
      for (int d = 0; d < N; d++) begin
        if (m_primed != 0 && int'(ready_i[d]) != m_prev[d]) m_rdy[d] = 1;
        m_prev[d] = int'(ready_i[d]);
      end
      m_primed = 1;
      if (seek_done_i) begin
        m_seek[seek_drv_i] = 1; m_fail[seek_drv_i] = int'(seek_fail_i); m_cyl[seek_drv_i] = int'(seek_cyl_i);
      end
      if (seek_start_i) m_busy[seek_drv_i] = 1;
      old_ndma = m_ndma;
      if (result_enter_i) m_ndma = 0;
      else if (exec_begin_i && non_dma_i) m_ndma = 1;
      if (result_enter_i || (byte_req_i && old_ndma != 0)) m_dirq = 1;
      else if (data_rd_i || data_wr_i) m_dirq = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int any;
      int busy;
      any = 0; busy = 0;
      for (int d = 0; d < N; d++) begin
        if (m_seek[d] != 0 || m_rdy[d] != 0) any = 1;
        busy |= m_busy[d] << d;
      end
      chk("R4/R8 irq", int'(irq_o), (m_dirq != 0 || any != 0) ? 1 : 0);
      chk("R2 ndma", int'(msr_ndma_o), m_ndma);
      chk("R11 busy", int'(msr_busy_o), busy);
      chk("R9 st0", int'(sense_st0_o), m_st0);
      chk("R5 pcn", int'(sense_pcn_o), m_pcn_out);
      chk("R10 nbytes", int'(sense_nbytes_o), m_nb);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clear_in();
    result_enter_i = 0; exec_begin_i = 0; byte_req_i = 0; data_rd_i = 0; data_wr_i = 0;
    seek_start_i = 0; seek_done_i = 0; seek_fail_i = 0; sense_i = 0;
  endtask

  task automatic seek_end(int drv, int cyl, bit fail);
    step(); seek_done_i = 1; seek_drv_i = 2'(drv); seek_cyl_i = CW'(cyl); seek_fail_i = fail;
    step(); clear_in();
  endtask

  task automatic sense();
    step(); sense_i = 1; step(); clear_in();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1;
    step(); step();
    // R12 reset state; R7 baseline on ready lines raises nothing
    chk("R12 irq", int'(irq_o), 0);
    chk("R12 outputs", int'({msr_ndma_o, msr_busy_o, sense_st0_o, sense_pcn_o, sense_nbytes_o}), 0);
    chk("R7 baseline", int'(irq_o), 0);

    // R1, R4
    result_enter_i = 1; step(); clear_in();
    chk("R1 irq", int'(irq_o), 1);
    data_rd_i = 1; step(); clear_in();
    chk("R4 rd clears", int'(irq_o), 0);

    // R3 gated, R2
    byte_req_i = 1; step(); clear_in();
    chk("R3 no ndma", int'(irq_o), 0);
    exec_begin_i = 1; non_dma_i = 0; step(); clear_in();
    chk("R2 dma mode", int'(msr_ndma_o), 0);
    exec_begin_i = 1; non_dma_i = 1; step(); clear_in();
    chk("R2 ndma set", int'(msr_ndma_o), 1);
    byte_req_i = 1; step(); clear_in();
    chk("R3 byte irq", int'(irq_o), 1);
    data_wr_i = 1; step(); clear_in();
    chk("R4 wr clears", int'(irq_o), 0);
    result_enter_i = 1; data_rd_i = 1; step(); clear_in();
    chk("R1 ndma drop", int'(msr_ndma_o), 0);
    chk("R4 raise wins", int'(irq_o), 1);
    data_rd_i = 1; step(); clear_in();
    chk("R4 cleared", int'(irq_o), 0);

    // R11, R5, R8
    seek_start_i = 1; seek_drv_i = 2; step(); clear_in();
    chk("R11 busy set", int'(msr_busy_o), 'b0100);
    seek_end(2, 37, 0);
    chk("R5 irq", int'(irq_o), 1);
    data_rd_i = 1; step(); clear_in();
    chk("R8 survives access", int'(irq_o), 1);
    sense();
    chk("R5 st0", int'(sense_st0_o), 'h22);
    chk("R5 pcn", int'(sense_pcn_o), 37);
    chk("R11 busy clear", int'(msr_busy_o), 0);
    chk("R9 drained", int'(irq_o), 0);

    // R10
    sense();
    chk("R10 st0", int'(sense_st0_o), 'h80);
    chk("R10 nbytes", int'(sense_nbytes_o), 1);

    // R6, R7, R9 ordering
    seek_end(3, 0, 1);
    seek_end(1, 5, 0);
    step(); ready_i = 4'b0110; step();
    sense();
    chk("R7 ready st0", int'(sense_st0_o), 'hC0);
    chk("R9 irq held", int'(irq_o), 1);
    sense();
    chk("R9 seek first", int'(sense_st0_o), 'h21);
    chk("R9 pcn", int'(sense_pcn_o), 5);
    sense();
    chk("R7 drive1 ready", int'(sense_st0_o), 'hC1);
    chk("R9 nbytes", int'(sense_nbytes_o), 2);
    sense();
    chk("R6 fail st0", int'(sense_st0_o), 'h73);
    chk("R9 empty irq", int'(irq_o), 0);
    sense();
    chk("R10 again", int'(sense_st0_o), 'h80);

    step(); step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule